// File: doc/BRIEF.md
# Rate-1/2 Convolutional Encoder with Zero Tail

This block turns a serial stream of message bits into a rate-1/2 coded stream. Each input step yields one 2-bit code pair from a two-stage shift register. The pair holds two parity bits. The first comes from generator 1 + x, the XOR of the current bit and the bit one step back. The second comes from generator 1 + x^2, the XOR of the current bit and the bit two steps back. A frame carries 13 message bits. After the 13th bit the block adds two zero bits of its own, which drives the register back to all zeros. A frame therefore takes 15 steps and yields 30 coded bits.

Both data edges use valid/ready. A transfer takes place on a rising clock edge where valid and ready are both high. Once `out_valid` is raised, the pair and its end marker stay fixed until `out_ready` accepts them. `in_ready` is high only when the output slot is empty or is being drained in that same cycle, and only during the message part of a frame. During the two tail steps `in_ready` is low, and the block moves forward on its own as the output drains. With `out_ready` held high the block runs one step per clock cycle.

Top module: `conv_tail_encoder`

## Requirements
- R1: `out_sym[1]` (sent first) equals the current input bit XOR the input bit of the previous step.
- R2: `out_sym[0]` (sent second) equals the current input bit XOR the input bit of two steps earlier.
- R3: Exactly 13 message bits are accepted per frame. `in_ready` stays low for the two tail steps that follow, and no pair is produced beyond those the frame calls for.
- R4: The two tail steps shift in zero bits, so each frame yields exactly 15 pairs.
- R5: `out_last` is 1 on the 15th pair of a frame and 0 on every other pair.
- R6: The shift register is all zeros at the first step of every frame, so the first pair of a frame depends only on that frame's first bit.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sym` and `out_last` hold their values on the next cycle.
- R8: `in_ready` is low whenever `out_valid` is high and `out_ready` is low.
- R9: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R10: With `out_ready` held high and input bits offered without gaps, a frame's last pair is taken 15 cycles after its first bit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A message bit is offered |
| in_ready | output | 1 | The block takes the offered bit on this edge |
| in_bit | input | 1 | Message bit |
| out_valid | output | 1 | A code pair is presented |
| out_ready | input | 1 | The downstream side takes the pair |
| out_sym | output | 2 | Code pair: bit 1 is the 1+x parity, bit 0 is the 1+x^2 parity |
| out_last | output | 1 | Marks the final pair of a frame |

## Verification
Two actions can fall on the same edge: handing a pair downstream, and taking in the next step. That next step may be a message bit or an internally generated tail zero. Holding `out_ready` high while bits arrive back to back makes the two coincide on every edge. Random stalls then split them apart again, including stalls that land during the tail. A scoreboard model compares every pair and end marker in order, so a lost, duplicated or early-accepted bit shows up as a miscompare. A cycle count across a full-rate frame confirms that no bubble is inserted.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;
  // Encoder memory: number of delay stages, also the tail length.
  localparam int MEM = 2;
  // Number of generator outputs per step.
  localparam int NOUT = 2;
  typedef logic [MEM:0] taps_t;        // bit j = tap at delay j
  typedef logic [NOUT-1:0] pair_t;     // bit NOUT-1 transmitted first
  // 1 + x  and  1 + x^2
  localparam taps_t TAPS_FIRST  = 3'b011;
  localparam taps_t TAPS_SECOND = 3'b101;
endpackage

// File: rtl/conv_frame_seq.sv
module conv_frame_seq #(
  parameter int MSG_BITS  = 13,
  parameter int TAIL_BITS = 2,
  localparam int STEPS    = MSG_BITS + TAIL_BITS,
  localparam int CW       = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  output logic [CW-1:0] step_idx,
  output logic          in_tail,
  output logic          frame_last
);
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (step_en) begin
      if (idx_q == CW'(STEPS - 1)) idx_q <= '0;
      else                         idx_q <= idx_q + 1'b1;
    end
  end

  assign step_idx   = idx_q;
  assign in_tail    = (idx_q >= CW'(MSG_BITS));
  assign frame_last = (idx_q == CW'(STEPS - 1));
endmodule

// File: rtl/conv_shift_core.sv
module conv_shift_core
  import conv_enc_pkg::*;
#(
  parameter taps_t G_FIRST  = TAPS_FIRST,
  parameter taps_t G_SECOND = TAPS_SECOND
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_en,
  input  logic           din,
  output pair_t          sym,
  output logic [MEM-1:0] state
);
  logic [MEM-1:0] st_q;
  logic [MEM:0]   window;   // window[0] = current bit, window[j] = bit j steps back
  taps_t          taps [NOUT];

  assign taps[0] = G_FIRST;
  assign taps[1] = G_SECOND;
  assign window  = {st_q, din};

  // One parity tree per generator; the first generator drives the MSB.
  for (genvar g = 0; g < NOUT; g++) begin : g_par
    assign sym[NOUT-1-g] = ^(window & taps[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= '0;
    else if (step_en) st_q <= window[MEM-1:0];
  end

  assign state = st_q;
endmodule

// File: rtl/conv_out_slot.sv
module conv_out_slot
  import conv_enc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  pair_t load_sym,
  input  logic  load_last,
  output logic  slot_free,
  output logic  out_valid,
  input  logic  out_ready,
  output pair_t out_sym,
  output logic  out_last
);
  logic  vld_q;
  pair_t sym_q;
  logic  last_q;

  assign slot_free = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sym_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      vld_q  <= 1'b1;
      sym_q  <= load_sym;
      last_q <= load_last;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign out_sym   = sym_q;
  assign out_last  = last_q;

  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sym) && $stable(out_last)));

  a_r8_no_load_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load);
endmodule

// File: rtl/conv_tail_encoder.sv
module conv_tail_encoder
  import conv_enc_pkg::*;
#(
  parameter int MSG_BITS = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_bit,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] out_sym,
  output logic       out_last
);
  localparam int TAIL_BITS = MEM;
  localparam int STEPS     = MSG_BITS + TAIL_BITS;
  localparam int CW        = $clog2(STEPS);

  logic          slot_free;
  logic          in_tail;
  logic          frame_last;
  logic [CW-1:0] step_idx;
  logic          step_en;
  logic          step_bit;
  pair_t         step_sym;
  logic [MEM-1:0] core_state;

  // A step fires when the output slot can take a pair and a bit is available:
  // a message bit from the port, or an internally made zero during the tail.
  assign in_ready = slot_free && !in_tail;
  assign step_en  = slot_free && (in_tail || in_valid);
  assign step_bit = in_tail ? 1'b0 : in_bit;

  conv_frame_seq #(.MSG_BITS(MSG_BITS), .TAIL_BITS(TAIL_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_en    (step_en),
    .step_idx   (step_idx),
    .in_tail    (in_tail),
    .frame_last (frame_last)
  );

  conv_shift_core #(.G_FIRST(TAPS_FIRST), .G_SECOND(TAPS_SECOND)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (step_en),
    .din     (step_bit),
    .sym     (step_sym),
    .state   (core_state)
  );

  conv_out_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (step_en),
    .load_sym  (step_sym),
    .load_last (frame_last),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sym   (out_sym),
    .out_last  (out_last)
  );

  // R6: the tail must leave the register empty when a new frame starts.
  a_r6_clear_at_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    (step_idx == '0) |-> (core_state == '0));

  a_r3_no_ready_in_tail: assert property (@(posedge clk) disable iff (!rst_n)
    in_tail |-> !in_ready);

  a_r5_last_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !frame_last) |=> !out_last);
endmodule

// File: tb/tb_conv_tail_encoder.sv
module tb_conv_tail_encoder;
  localparam int MSG   = 13;
  localparam int STEPS = 15;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_bit = 1'b0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, out_last;
  logic [1:0] out_sym;

  always #5 clk = ~clk;

  conv_tail_encoder #(.MSG_BITS(MSG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .out_valid(out_valid), .out_ready(out_ready),
    .out_sym(out_sym), .out_last(out_last)
  );

  typedef struct { logic [1:0] sym; logic last; int idx; } exp_t;
  exp_t q[$];

  int          checks = 0;
  int          fails  = 0;
  int unsigned cyc    = 0;
  int unsigned first_acc = 0;
  bit          full_rate = 1'b1;
  int          max_gap = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Offer one bit; returns once it has been taken on a clock edge.
  task automatic send_bit(input logic b, output int unsigned acc);
    int gap;
    gap = (max_gap == 0) ? 0 : int'($urandom % (max_gap + 1));
    for (int g = 0; g < gap; g++) @(negedge clk);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_bit   = b;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    acc      = cyc;
    in_valid = 1'b0;
    in_bit   = $urandom % 2;
  endtask

  // Model: fresh register per frame (R6), 13 data bits then two zeros (R4).
  task automatic send_frame(input logic [MSG-1:0] msg);
    logic p1, p2, b;
    int unsigned acc;
    exp_t e;
    p1 = 1'b0; p2 = 1'b0;
    for (int i = 0; i < STEPS; i++) begin
      b = (i < MSG) ? msg[i] : 1'b0;
      e.sym  = {b ^ p1, b ^ p2};
      e.last = (i == STEPS - 1);
      e.idx  = i;
      q.push_back(e);
      p2 = p1; p1 = b;
    end
    for (int i = 0; i < MSG; i++) begin
      send_bit(msg[i], acc);
      if (i == 0) first_acc = acc;
    end
  endtask

  // Monitor and scoreboard.
  initial begin
    bit         prev_stall = 1'b0;
    logic [1:0] prev_sym = '0;
    logic       prev_last = 1'b0;
    exp_t       e;
    string      t1, t2;
    forever begin
      @(negedge clk);
      out_ready = full_rate ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (rst_n && prev_stall) begin
        check(out_valid === 1'b1, "R7", "valid held", out_valid, 1);
        check(out_sym === prev_sym, "R7", "sym held", out_sym, prev_sym);
        check(out_last === prev_last, "R7", "last held", out_last, prev_last);
      end
      if (rst_n && out_valid && !out_ready)
        check(in_ready === 1'b0, "R8", "in_ready while stalled", in_ready, 0);
      if (rst_n && out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R3", "unexpected extra pair", 1, 0);
        end else begin
          e = q.pop_front();
          t1 = (e.idx == 0) ? "R6" : (e.idx >= MSG) ? "R4" : "R1";
          t2 = (e.idx == 0) ? "R6" : (e.idx >= MSG) ? "R4" : "R2";
          check(out_sym[1] === e.sym[1], t1, $sformatf("g0 step %0d", e.idx), out_sym[1], e.sym[1]);
          check(out_sym[0] === e.sym[0], t2, $sformatf("g1 step %0d", e.idx), out_sym[0], e.sym[0]);
          check(out_last === e.last, "R5", $sformatf("last step %0d", e.idx), out_last, e.last);
          if (full_rate && e.idx == STEPS - 1)
            check((cyc - first_acc) == 14, "R10", "frame cycles",
                  int'(cyc - first_acc), 14);
        end
      end
      prev_stall = rst_n && out_valid && !out_ready;
      prev_sym   = out_sym;
      prev_last  = out_last;
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    finish_run();
  end

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(q.size() == 0, "R4", "all pairs delivered", q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R9", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #2;
    check(in_ready === 1'b1, "R9", "in_ready after reset", in_ready, 1);
    check(out_valid === 1'b0, "R9", "out_valid after reset", out_valid, 0);

    // Full rate: pair drain and next step coincide on every edge (R10).
    send_frame('1);
    send_frame(13'b0101010101010);
    send_frame('0);
    send_frame(13'h1A5B);
    drain();

    // Random stalls and input gaps; next frame offered during the tail (R3).
    full_rate = 1'b0;
    max_gap = 2;
    for (int f = 0; f < 40; f++) send_frame(13'($urandom));
    max_gap = 0;
    for (int f = 0; f < 20; f++) send_frame(13'($urandom));
    drain();

    full_rate = 1'b1;
    repeat (6) @(negedge clk);
    #2;
    check(out_valid === 1'b0, "R3", "no pair after frames end", out_valid, 0);
    finish_run();
  end
endmodule